// File: doc/BRIEF.md
# Accumulator Processor with Index Register

This block is a small multi-cycle processor built around one 16-bit accumulator and one 11-bit index register. Instructions and data live in the same external synchronous single-port memory. Because of that, a program may read and rewrite the address field of its own instructions to walk through arrays. It can also do the same work with the index register, whose test-and-increment jump closes counting loops that run from a negative count up to zero.

Each instruction takes a fetch cycle and a decode cycle. Operations that read an operand take one more cycle, in which the memory returns the operand. A halt instruction, or an unassigned opcode, stops fetching for good until the next reset and raises the halt output.

Top module: `acc_cpu`

## Requirements
- R1: Instruction word format: bits [15:12] opcode, bit [11] index flag, bits [10:0] address or immediate field. While reset is held, and on the first cycle after it is released, the block fetches from address 0, does not write, and does not signal halt. AC, IX and the program counter all start at 0.
- R2: The direct memory operations (opcode 1 load, 2 store, 3 add, 4 subtract) act on M[field]. Load sets AC to the word. Store writes AC to the word. Add and subtract change AC modulo 2^16.
- R3: Opcode 5 doubles AC by a left shift, with a zero shifted in. Opcode 6 halves AC by an arithmetic right shift that keeps the sign bit.
- R4: Opcode 7 sets the program counter to the field. Opcode 8 does so only when AC bit 15 is 0, and otherwise falls through to the next word.
- R5: Opcode 9 loads AC with bits [10:0] of M[field], with zeros above. Opcode 10 writes AC[10:0] into bits [10:0] of M[field] and keeps that word's bits [15:11].
- R6: When the index flag is set on opcodes 1 to 4, the memory address is (field + IX) modulo 2^11.
- R7: Opcode 11 jumps to the field when IX is 0. Otherwise it adds 1 to IX and falls through.
- R8: Opcode 12 loads IX with bits [10:0] of M[field]. Opcode 13 writes IX to M[field], sign-extended to 16 bits. Opcode 14 adds the field to IX modulo 2^11.
- R9: Opcode 0 and opcode 15 halt the block. Halt then stays asserted, no later instruction runs or writes memory, and the memory address holds still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 11 | Memory word address |
| mem_we | output | 1 | Memory write enable for this cycle |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Word read at the address of the previous cycle |
| halt | output | 1 | High once the block has stopped |

## Verification
The checker watches the control behaviour on every cycle. It checks that the first fetch after reset comes from address 0, that writes never fall on two cycles in a row, and that the halt state is sticky, does not write and keeps the address steady. The data results can only be shown by the bench's scenarios, which run programs and compare memory with values worked out from the requirements. These include arithmetic wrap, shift signs, branch direction, field-only load and store, index address wrap, truncation and sign extension of the index register, and two forms of a vector add: one that rewrites its own instructions and one that loops on the index register.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    parameter int unsigned WORD_W  = 16;
    parameter int unsigned OP_W    = 4;
    parameter int unsigned FIELD_W = 11;

    localparam int unsigned IX_W    = FIELD_W;
    localparam int unsigned IDX_BIT = FIELD_W;
    localparam int unsigned HI_W    = WORD_W - FIELD_W;
    localparam int unsigned OP_LSB  = WORD_W - OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_HLT    = 4'd0,
        OP_LOAD   = 4'd1,
        OP_STORE  = 4'd2,
        OP_ADD    = 4'd3,
        OP_SUB    = 4'd4,
        OP_SHL    = 4'd5,
        OP_SHR    = 4'd6,
        OP_JUMP   = 4'd7,
        OP_JGE    = 4'd8,
        OP_LDFLD  = 4'd9,
        OP_STFLD  = 4'd10,
        OP_JZX    = 4'd11,
        OP_LDX    = 4'd12,
        OP_STX    = 4'd13,
        OP_INCX   = 4'd14,
        OP_BAD    = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_HALT
    } state_e;

    typedef struct packed {
        state_e              st;
        logic [WORD_W-1:0]   ac;
        logic [IX_W-1:0]     ix;
        logic [FIELD_W-1:0]  pc;
        logic [WORD_W-1:0]   ir;
        logic [FIELD_W-1:0]  ea;
    } cpu_regs_t;

endpackage

// File: rtl/acc_ea_gen.sv
module acc_ea_gen
    import acc_cpu_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               idx_en,
    input  logic [IX_W-1:0]    ix,
    output logic [FIELD_W-1:0] ea
);
    always_comb begin
        ea = idx_en ? (field + ix) : field;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_cpu_pkg::*;
(
    input  opcode_e            op,
    input  logic [WORD_W-1:0]  ac,
    input  logic [WORD_W-1:0]  opnd,
    output logic [WORD_W-1:0]  res
);
    always_comb begin
        unique case (op)
            OP_LOAD:  res = opnd;
            OP_ADD:   res = ac + opnd;
            OP_SUB:   res = ac - opnd;
            OP_SHL:   res = {ac[WORD_W-2:0], 1'b0};
            OP_SHR:   res = {ac[WORD_W-1], ac[WORD_W-1:1]};
            OP_LDFLD: res = {{HI_W{1'b0}}, opnd[FIELD_W-1:0]};
            default:  res = ac;
        endcase
    end
endmodule

// File: rtl/acc_flow.sv
module acc_flow
    import acc_cpu_pkg::*;
(
    input  opcode_e            op,
    input  logic [FIELD_W-1:0] field,
    input  logic [WORD_W-1:0]  ac,
    input  logic [IX_W-1:0]    ix,
    input  logic [FIELD_W-1:0] pc,
    output logic [FIELD_W-1:0] pc_next,
    output logic [IX_W-1:0]    ix_next,
    output logic [FIELD_W-1:0] pc_inc
);
    always_comb begin
        pc_inc  = pc + 1'b1;
        pc_next = pc_inc;
        ix_next = ix;
        unique case (op)
            OP_JUMP: pc_next = field;
            OP_JGE: begin
                if (!ac[WORD_W-1]) pc_next = field;
            end
            OP_JZX: begin
                if (ix == '0) pc_next = field;
                else          ix_next = ix + 1'b1;
            end
            OP_INCX: ix_next = ix + field;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    output logic [FIELD_W-1:0]  mem_addr,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                halt
);
    cpu_regs_t r_d, r_q;

    opcode_e            dec_op, exe_op, alu_op;
    logic [FIELD_W-1:0] dec_field;
    logic               dec_idx;
    logic               dec_mem_op;
    logic [FIELD_W-1:0] dec_ea;
    logic [WORD_W-1:0]  alu_res;
    logic [FIELD_W-1:0] flow_pc, flow_pc_inc;
    logic [IX_W-1:0]    flow_ix;

    assign dec_op     = opcode_e'(mem_rdata[WORD_W-1:OP_LSB]);
    assign exe_op     = opcode_e'(r_q.ir[WORD_W-1:OP_LSB]);
    assign dec_field  = mem_rdata[FIELD_W-1:0];
    assign dec_mem_op = (dec_op == OP_LOAD) || (dec_op == OP_STORE) ||
                        (dec_op == OP_ADD)  || (dec_op == OP_SUB);
    assign dec_idx    = mem_rdata[IDX_BIT] & dec_mem_op;
    assign alu_op     = (r_q.st == ST_DECODE) ? dec_op : exe_op;

    acc_ea_gen u_ea (
        .field  (dec_field),
        .idx_en (dec_idx),
        .ix     (r_q.ix),
        .ea     (dec_ea)
    );

    acc_alu u_alu (
        .op   (alu_op),
        .ac   (r_q.ac),
        .opnd (mem_rdata),
        .res  (alu_res)
    );

    acc_flow u_flow (
        .op      (dec_op),
        .field   (dec_field),
        .ac      (r_q.ac),
        .ix      (r_q.ix),
        .pc      (r_q.pc),
        .pc_next (flow_pc),
        .ix_next (flow_ix),
        .pc_inc  (flow_pc_inc)
    );

    always_comb begin
        r_d       = r_q;
        mem_addr  = r_q.pc;
        mem_we    = 1'b0;
        mem_wdata = r_q.ac;
        halt      = 1'b0;
        unique case (r_q.st)
            ST_FETCH: begin
                r_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.ir = mem_rdata;
                r_d.ea = dec_ea;
                unique case (dec_op)
                    OP_HLT, OP_BAD: begin
                        r_d.st = ST_HALT;
                    end
                    OP_SHL, OP_SHR: begin
                        r_d.ac = alu_res;
                        r_d.pc = flow_pc_inc;
                        r_d.st = ST_FETCH;
                    end
                    OP_JUMP, OP_JGE, OP_JZX, OP_INCX: begin
                        r_d.pc = flow_pc;
                        r_d.ix = flow_ix;
                        r_d.st = ST_FETCH;
                    end
                    OP_STORE: begin
                        mem_addr  = dec_ea;
                        mem_we    = 1'b1;
                        mem_wdata = r_q.ac;
                        r_d.pc    = flow_pc_inc;
                        r_d.st    = ST_FETCH;
                    end
                    OP_STX: begin
                        mem_addr  = dec_ea;
                        mem_we    = 1'b1;
                        mem_wdata = {{HI_W{r_q.ix[IX_W-1]}}, r_q.ix};
                        r_d.pc    = flow_pc_inc;
                        r_d.st    = ST_FETCH;
                    end
                    default: begin
                        mem_addr = dec_ea;
                        r_d.st   = ST_EXEC;
                    end
                endcase
            end
            ST_EXEC: begin
                r_d.pc = r_q.pc + 1'b1;
                r_d.st = ST_FETCH;
                unique case (exe_op)
                    OP_LDX: begin
                        r_d.ix = mem_rdata[IX_W-1:0];
                    end
                    OP_STFLD: begin
                        mem_addr  = r_q.ea;
                        mem_we    = 1'b1;
                        mem_wdata = {mem_rdata[WORD_W-1:FIELD_W], r_q.ac[FIELD_W-1:0]};
                    end
                    default: begin
                        r_d.ac = alu_res;
                    end
                endcase
            end
            ST_HALT: begin
                halt = 1'b1;
            end
            default: begin
                r_d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= ST_FETCH;
            r_q.ac <= '0;
            r_q.ix <= '0;
            r_q.pc <= '0;
            r_q.ir <= '0;
            r_q.ea <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [FIELD_W-1:0] mem_addr,
    input logic               mem_we,
    input logic               halt
);
    // R1
    first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == '0 && !mem_we && !halt));

    // R2
    write_gap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halt |-> !mem_we);

    // R9
    halt_addr_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(mem_addr));
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halt     (halt)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
    localparam logic [3:0] HLT = 4'd0, LD = 4'd1, ST = 4'd2, ADD = 4'd3, SUB = 4'd4,
                           SHL = 4'd5, SHR = 4'd6, JMP = 4'd7, JGE = 4'd8, LDF = 4'd9,
                           STF = 4'd10, JZX = 4'd11, LDX = 4'd12, STX = 4'd13,
                           INX = 4'd14, BAD = 4'd15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halt;
    logic [15:0] mem [0:2047];

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    acc_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halt      (halt)
    );

    function automatic logic [15:0] ins(logic [3:0] op, logic x, logic [10:0] f);
        return {op, x, f};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_prog();
        rst = 1'b1;
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    endtask

    task automatic go_and_wait(string req);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (halt) break;
        end
        check({req, " halted"}, {15'd0, halt}, 16'd1);
    endtask

    task automatic t_reset();
        start_prog();
        mem[0] = ins(HLT, 1'b0, 11'd0);
        repeat (3) @(negedge clk);
        check("R1 halt low in reset", {15'd0, halt}, 16'd0);
        check("R1 no write in reset", {15'd0, mem_we}, 16'd0);
        rst = 1'b0;
        #1;
        check("R1 first fetch address", {5'd0, mem_addr}, 16'd0);
        check("R1 no halt at first fetch", {15'd0, halt}, 16'd0);
        repeat (4) @(negedge clk);
        check("R9 HLT opcode 0 halts", {15'd0, halt}, 16'd1);
    endtask

    task automatic t_arith();
        start_prog();
        mem[100] = 16'd5;  mem[101] = 16'd7;  mem[102] = 16'd20;
        mem[103] = 16'h7FFF; mem[104] = 16'd1; mem[105] = 16'd3;
        mem[0]  = ins(LD,  1'b0, 11'd100);
        mem[1]  = ins(ADD, 1'b0, 11'd101);
        mem[2]  = ins(ST,  1'b0, 11'd110);
        mem[3]  = ins(SUB, 1'b0, 11'd102);
        mem[4]  = ins(ST,  1'b0, 11'd111);
        mem[5]  = ins(SHL, 1'b0, 11'd0);
        mem[6]  = ins(ST,  1'b0, 11'd112);
        mem[7]  = ins(SHR, 1'b0, 11'd0);
        mem[8]  = ins(SHR, 1'b0, 11'd0);
        mem[9]  = ins(ST,  1'b0, 11'd113);
        mem[10] = ins(LD,  1'b0, 11'd103);
        mem[11] = ins(ADD, 1'b0, 11'd104);
        mem[12] = ins(ST,  1'b0, 11'd114);
        mem[13] = ins(LD,  1'b0, 11'd105);
        mem[14] = ins(SHR, 1'b0, 11'd0);
        mem[15] = ins(ST,  1'b0, 11'd115);
        mem[16] = ins(HLT, 1'b0, 11'd0);
        go_and_wait("R2");
        check("R2 load+add", mem[110], 16'd12);
        check("R2 subtract to negative", mem[111], 16'hFFF8);
        check("R3 shift left doubles", mem[112], 16'hFFF0);
        check("R3 arithmetic shift right keeps sign", mem[113], 16'hFFFC);
        check("R2 add wraps mod 2^16", mem[114], 16'h8000);
        check("R3 shift right positive", mem[115], 16'd1);
    endtask

    task automatic t_jumps();
        start_prog();
        mem[100] = 16'd0; mem[101] = 16'h8000; mem[102] = 16'h7FFF;
        mem[110] = 16'hDEAD; mem[111] = 16'hDEAD; mem[112] = 16'hDEAD; mem[113] = 16'hDEAD;
        mem[0]  = ins(LD,  1'b0, 11'd100);
        mem[1]  = ins(JGE, 1'b0, 11'd4);
        mem[2]  = ins(HLT, 1'b0, 11'd0);
        mem[3]  = ins(HLT, 1'b0, 11'd0);
        mem[4]  = ins(ST,  1'b0, 11'd110);
        mem[5]  = ins(LD,  1'b0, 11'd101);
        mem[6]  = ins(JGE, 1'b0, 11'd9);
        mem[7]  = ins(ST,  1'b0, 11'd111);
        mem[8]  = ins(JMP, 1'b0, 11'd11);
        mem[9]  = ins(ST,  1'b0, 11'd112);
        mem[10] = ins(HLT, 1'b0, 11'd0);
        mem[11] = ins(LD,  1'b0, 11'd102);
        mem[12] = ins(JGE, 1'b0, 11'd14);
        mem[13] = ins(HLT, 1'b0, 11'd0);
        mem[14] = ins(ST,  1'b0, 11'd113);
        mem[15] = ins(HLT, 1'b0, 11'd0);
        go_and_wait("R4");
        check("R4 JGE taken on zero", mem[110], 16'd0);
        check("R4 JGE falls through on negative", mem[111], 16'h8000);
        check("R4 JGE target skipped on negative", mem[112], 16'hDEAD);
        check("R4 JUMP then JGE taken on positive", mem[113], 16'h7FFF);
    endtask

    task automatic t_field();
        start_prog();
        mem[200] = 16'hA123; mem[201] = 16'h5000; mem[202] = 16'hFFFF;
        mem[0] = ins(LDF, 1'b0, 11'd200);
        mem[1] = ins(ST,  1'b0, 11'd210);
        mem[2] = ins(LD,  1'b0, 11'd202);
        mem[3] = ins(STF, 1'b0, 11'd201);
        mem[4] = ins(HLT, 1'b0, 11'd0);
        go_and_wait("R5");
        check("R5 field load zero-extends", mem[210], 16'h0123);
        check("R5 field store keeps top bits", mem[201], 16'h57FF);
        check("R5 field source untouched", mem[200], 16'hA123);
    endtask

    task automatic load_vectors(int n);
        for (int k = 1; k <= n; k++) begin
            mem[64 + k] = 16'(k * 16'h3001);
            mem[80 + k] = 16'(16'h7000 + k);
        end
    endtask

    task automatic check_vectors(string req, int n);
        for (int k = 0; k <= n + 1; k++) begin
            logic [15:0] exp;
            exp = (k >= 1 && k <= n) ? 16'(mem[64 + k] + mem[80 + k]) : 16'h0000;
            check(req, mem[96 + k], exp);
        end
    endtask

    task automatic t_selfmod();
        int n = 4;
        start_prog();
        load_vectors(n);
        mem[60] = 16'(-n);
        mem[61] = 16'd1;
        mem[0]  = ins(LD,  1'b0, 11'd60);
        mem[1]  = ins(JGE, 1'b0, 11'd17);
        mem[2]  = ins(ADD, 1'b0, 11'd61);
        mem[3]  = ins(ST,  1'b0, 11'd60);
        mem[4]  = ins(LD,  1'b0, 11'd65);
        mem[5]  = ins(ADD, 1'b0, 11'd81);
        mem[6]  = ins(ST,  1'b0, 11'd97);
        mem[7]  = ins(LDF, 1'b0, 11'd4);
        mem[8]  = ins(ADD, 1'b0, 11'd61);
        mem[9]  = ins(STF, 1'b0, 11'd4);
        mem[10] = ins(LDF, 1'b0, 11'd5);
        mem[11] = ins(ADD, 1'b0, 11'd61);
        mem[12] = ins(STF, 1'b0, 11'd5);
        mem[13] = ins(LDF, 1'b0, 11'd6);
        mem[14] = ins(ADD, 1'b0, 11'd61);
        mem[15] = ins(STF, 1'b0, 11'd6);
        mem[16] = ins(JMP, 1'b0, 11'd0);
        mem[17] = ins(HLT, 1'b0, 11'd0);
        go_and_wait("R5 self-modifying add");
        check_vectors("R5 self-modifying vector add", n);
        check("R5 rewritten load keeps opcode", mem[4], ins(LD, 1'b0, 11'(65 + n)));
        check("R5 rewritten store keeps opcode", mem[6], ins(ST, 1'b0, 11'(97 + n)));
        check("R2 loop counter reaches zero", mem[60], 16'd0);
    endtask

    task automatic t_index();
        int n = 5;
        start_prog();
        load_vectors(n);
        mem[60] = 16'(-n);
        mem[0] = ins(LDX, 1'b0, 11'd60);
        mem[1] = ins(JZX, 1'b0, 11'd6);
        mem[2] = ins(LD,  1'b1, 11'(64 + n));
        mem[3] = ins(ADD, 1'b1, 11'(80 + n));
        mem[4] = ins(ST,  1'b1, 11'(96 + n));
        mem[5] = ins(JMP, 1'b0, 11'd1);
        mem[6] = ins(STX, 1'b0, 11'd62);
        mem[7] = ins(HLT, 1'b0, 11'd0);
        go_and_wait("R7 index loop");
        check_vectors("R6 R7 indexed vector add", n);
        check("R7 IX counted up to zero", mem[62], 16'd0);
    endtask

    task automatic t_ixops();
        start_prog();
        mem[100] = 16'hF7FE;
        mem[0] = ins(LDX, 1'b0, 11'd100);
        mem[1] = ins(STX, 1'b0, 11'd110);
        mem[2] = ins(INX, 1'b0, 11'd3);
        mem[3] = ins(STX, 1'b0, 11'd111);
        mem[4] = ins(INX, 1'b0, 11'h7FF);
        mem[5] = ins(STX, 1'b0, 11'd112);
        mem[6] = ins(LDX, 1'b0, 11'd101);
        mem[7] = ins(INX, 1'b0, 11'h7FF);
        mem[8] = ins(LD,  1'b1, 11'd0);
        mem[9] = ins(ST,  1'b0, 11'd113);
        mem[10] = ins(HLT, 1'b0, 11'd0);
        mem[101] = 16'd0;
        mem[2047] = 16'hBEEF;
        go_and_wait("R8");
        check("R8 IX load truncates, store sign-extends", mem[110], 16'hFFFE);
        check("R8 INC immediate adds", mem[111], 16'h0001);
        check("R8 INC wraps mod 2^11", mem[112], 16'h0000);
        check("R6 indexed address wraps mod 2^11", mem[113], 16'hBEEF);
    endtask

    task automatic t_halt();
        logic [10:0] held;
        start_prog();
        mem[100] = 16'h1234;
        mem[0] = ins(LD,  1'b0, 11'd100);
        mem[1] = ins(BAD, 1'b0, 11'd0);
        mem[2] = ins(ST,  1'b0, 11'd110);
        mem[3] = ins(HLT, 1'b0, 11'd0);
        go_and_wait("R9 opcode 15");
        held = mem_addr;
        repeat (20) @(negedge clk);
        check("R9 halt stays high", {15'd0, halt}, 16'd1);
        check("R9 no write after opcode 15", mem[110], 16'h0000);
        check("R9 address held while halted", {5'd0, mem_addr}, {5'd0, held});
        check("R9 no write enable while halted", {15'd0, mem_we}, 16'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_arith();
        t_jumps();
        t_field();
        t_selfmod();
        t_index();
        t_ixops();
        t_halt();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule